// File: doc/BRIEF.md
# Debug Address Breakpoint Matcher

This unit holds four breakpoint address slots and one control word. Each cycle it can compare the current instruction pointer and one data access against every slot. The control word gives each slot an enable, a match kind and a span length. Hits are collected into a 4-bit field at the bottom of a status word. When at least one enabled slot hits, the unit raises a one-cycle debug-exception pulse.

A pipeline writes the slot addresses and the control word through a simple write port. It presents the fetch address with a valid strobe, and a data access with address, size and direction. A force input lets a trap path refresh the status field even when no enabled slot matched.

Top module: `debug_bp_match`

## Requirements
- R1: Reset is synchronous and active high. It sets `status` to 32'hFFFF0FF0, the control word to 32'h00000400 and all four slot addresses to zero. `dbg_exc` is 0 after reset.
- R2: The match kind is the 2-bit field at control bits 17+4n:16+4n. Kind 0 is an instruction match: slot n matches when `fetch_valid` is 1 and `fetch_ip` equals the slot address exactly.
- R3: Kind 1 matches only data accesses with `acc_write`=1. A read to the same bytes does not match.
- R4: Kind 3 matches data reads and data writes.
- R5: Kind 2 never matches, for any input.
- R6: The length field is at control bits 19+4n:18+4n, with codes 0/1/2/3 meaning 1/2/8/4 bytes. The slot address is aligned down to that length. `acc_size` codes 0/1/2/3 mean 1/2/4/8 bytes. A data access matches when any of its bytes falls inside the slot's aligned span.
- R7: When status is updated, bits 3:0 are replaced by the hit of every slot, enabled or not. Bits 31:4 never change.
- R8: Status updates on the clock edge after an evaluation where an enabled slot matched or `force_upd` was 1. Otherwise status holds, even if a disabled slot matched.
- R9: `dbg_exc` is 1 for one cycle, on the edge after an evaluation where an enabled slot matched. `force_upd` alone never raises it.
- R10: Slot n is enabled when control bit 2n or bit 2n+1 is set.
- R11: A register write with `wr_sel` 0..3 loads that slot address, and `wr_sel`=4 loads the control word. An evaluation in the same cycle as a write uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | 0..3 slot address, 4 control word |
| wr_data | input | 32 | Write data |
| fetch_valid | input | 1 | Instruction pointer is valid this cycle |
| fetch_ip | input | 32 | Current instruction pointer |
| acc_valid | input | 1 | Data access strobe |
| acc_write | input | 1 | 1 = data write, 0 = data read |
| acc_size | input | 2 | Access size code (1/2/4/8 bytes) |
| acc_addr | input | 32 | Data access start address |
| force_upd | input | 1 | Update status without an enabled hit |
| status | output | 32 | Status word, hit bits in 3:0 |
| dbg_exc | output | 1 | Debug-exception pulse |

## Verification
A register write and an evaluation can land in the same cycle. One directed case moves an enabled slot's address away in the very cycle its old address is fetched. It expects a hit on that cycle and no hit on the next fetch of the old address. The random phase mixes writes, fetches, data accesses and forced updates freely. Each cycle it is judged by a bench model that evaluates against the pre-write register contents before it applies the write.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    localparam int SLOTS    = 4;
    localparam int CTRL_W   = 32;
    localparam int STAT_W   = 32;
    localparam int SEL_W    = $clog2(SLOTS + 1);
    localparam logic [STAT_W-1:0] STAT_RST = 32'hFFFF_0FF0;
    localparam logic [CTRL_W-1:0] CTRL_RST = 32'h0000_0400;

    typedef enum logic [1:0] {
        BK_EXEC  = 2'd0,
        BK_WRITE = 2'd1,
        BK_IO    = 2'd2,
        BK_RW    = 2'd3
    } bk_kind_e;

    typedef struct packed {
        logic       en;
        bk_kind_e   kind;
        logic [1:0] len;
    } slot_cfg_t;

    function automatic slot_cfg_t decode_slot(input logic [CTRL_W-1:0] c, input int n);
        slot_cfg_t s;
        s.en   = c[2*n] | c[2*n+1];
        s.kind = bk_kind_e'(c[16+4*n +: 2]);
        s.len  = c[18+4*n +: 2];
        return s;
    endfunction

    function automatic logic [3:0] span_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            2'd2:    return 4'd8;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic [3:0] access_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/bpm_regs.sv
module bpm_regs
    import bpm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [AW-1:0]             wr_data,
    output logic [SLOTS-1:0][AW-1:0]  slot_addr,
    output logic [CTRL_W-1:0]         ctrl
);

    for (genvar n = 0; n < SLOTS; n++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst)
                slot_addr[n] <= '0;
            else if (wr_en && wr_sel == SEL_W'(n))
                slot_addr[n] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= CTRL_RST;
        else if (wr_en && wr_sel == SEL_W'(SLOTS))
            ctrl <= CTRL_W'(wr_data);
    end

endmodule

// File: rtl/bpm_slot_cmp.sv
module bpm_slot_cmp
    import bpm_pkg::*;
#(
    parameter int AW = 32
) (
    input  slot_cfg_t       cfg,
    input  logic [AW-1:0]   base,
    input  logic            fetch_valid,
    input  logic [AW-1:0]   fetch_ip,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [1:0]      acc_size,
    input  logic [AW-1:0]   acc_addr,
    output logic            hit
);

    logic [AW-1:0] span_mask;
    logic [AW:0]   slot_lo, slot_hi, acc_lo, acc_hi;
    logic          overlap;

    always_comb begin
        span_mask = AW'(span_bytes(cfg.len)) - AW'(1);
        slot_lo   = {1'b0, base & ~span_mask};
        slot_hi   = slot_lo + (AW+1)'(span_mask);
        acc_lo    = {1'b0, acc_addr};
        acc_hi    = acc_lo + (AW+1)'(access_bytes(acc_size)) - (AW+1)'(1);
        overlap   = (acc_lo <= slot_hi) && (slot_lo <= acc_hi);
        case (cfg.kind)
            BK_EXEC:  hit = fetch_valid && (fetch_ip == base);
            BK_WRITE: hit = acc_valid && acc_write && overlap;
            BK_RW:    hit = acc_valid && overlap;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bpm_status.sv
module bpm_status
    import bpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SLOTS-1:0]   hit,
    input  logic [SLOTS-1:0]   en,
    input  logic               force_upd,
    output logic [STAT_W-1:0]  status,
    output logic               dbg_exc
);

    logic live;
    assign live = |(hit & en);

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= STAT_RST;
            dbg_exc <= 1'b0;
        end else begin
            if (live || force_upd)
                status <= {status[STAT_W-1:SLOTS], hit};
            dbg_exc <= live;
        end
    end

endmodule

// File: rtl/debug_bp_match.sv
module debug_bp_match
    import bpm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [AW-1:0]      wr_data,
    input  logic               fetch_valid,
    input  logic [AW-1:0]      fetch_ip,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_size,
    input  logic [AW-1:0]      acc_addr,
    input  logic               force_upd,
    output logic [31:0]        status,
    output logic               dbg_exc
);

    logic [SLOTS-1:0][AW-1:0] slot_addr;
    logic [CTRL_W-1:0]        ctrl;
    logic [SLOTS-1:0]         hit;
    logic [SLOTS-1:0]         en;

    bpm_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (SEL_W'(wr_sel)),
        .wr_data   (wr_data),
        .slot_addr (slot_addr),
        .ctrl      (ctrl)
    );

    for (genvar n = 0; n < SLOTS; n++) begin : g_slot
        slot_cfg_t cfg;
        assign cfg   = decode_slot(ctrl, n);
        assign en[n] = cfg.en;
        bpm_slot_cmp #(.AW(AW)) u_cmp (
            .cfg         (cfg),
            .base        (slot_addr[n]),
            .fetch_valid (fetch_valid),
            .fetch_ip    (fetch_ip),
            .acc_valid   (acc_valid),
            .acc_write   (acc_write),
            .acc_size    (acc_size),
            .acc_addr    (acc_addr),
            .hit         (hit[n])
        );
    end

    bpm_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .en        (en),
        .force_upd (force_upd),
        .status    (status),
        .dbg_exc   (dbg_exc)
    );

endmodule

// File: rtl/bpm_checker.sv
module bpm_checker
    import bpm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fetch_valid,
    input  logic [AW-1:0]             fetch_ip,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic                      force_upd,
    input  logic [CTRL_W-1:0]         ctrl,
    input  logic [SLOTS-1:0][AW-1:0]  slot_addr,
    input  logic [SLOTS-1:0]          hit,
    input  logic [STAT_W-1:0]         status,
    input  logic                      dbg_exc
);

    a_r8_status_hold: assert property (@(posedge clk) disable iff (rst)
        (status != $past(status)) |-> (dbg_exc || $past(force_upd)));

    a_r9_exc_has_hit: assert property (@(posedge clk) disable iff (rst)
        dbg_exc |-> (status[SLOTS-1:0] != '0));

    a_r7_upper_stable: assert property (@(posedge clk) disable iff (rst)
        $stable(status[STAT_W-1:SLOTS]));

    for (genvar n = 0; n < SLOTS; n++) begin : g_chk
        a_r5_io_never: assert property (@(posedge clk) disable iff (rst)
            (ctrl[16+4*n +: 2] == 2'd2) |-> !hit[n]);

        a_r2_exec_match: assert property (@(posedge clk) disable iff (rst)
            ((ctrl[16+4*n +: 2] == 2'd0) && hit[n]) |-> (fetch_valid && fetch_ip == slot_addr[n]));

        a_r3_write_only: assert property (@(posedge clk) disable iff (rst)
            ((ctrl[16+4*n +: 2] == 2'd1) && hit[n]) |-> (acc_valid && acc_write));
    end

endmodule

bind debug_bp_match bpm_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_ip    (fetch_ip),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .force_upd   (force_upd),
    .ctrl        (ctrl),
    .slot_addr   (slot_addr),
    .hit         (hit),
    .status      (status),
    .dbg_exc     (dbg_exc)
);

// File: tb/debug_bp_match_tb.sv
module debug_bp_match_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_ip = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_addr = '0;
    logic        force_upd = 1'b0;
    logic [31:0] status;
    logic        dbg_exc;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [31:0] m_status;
    logic        m_exc;

    always #10 clk = ~clk;

    debug_bp_match u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fetch_valid(fetch_valid), .fetch_ip(fetch_ip), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_size(acc_size), .acc_addr(acc_addr),
        .force_upd(force_upd), .status(status), .dbg_exc(dbg_exc)
    );

    function automatic logic [31:0] slot_bits(int n, bit en, bit glob, int kind, int len);
        logic [31:0] v = '0;
        v[2*n + (glob ? 1 : 0)] = en;
        v[16+4*n +: 2] = 2'(kind);
        v[18+4*n +: 2] = 2'(len);
        return v;
    endfunction

    function automatic bit ref_hit(int n);
        longint unsigned blen, base, abytes, alo;
        int kind = int'(m_ctrl[16+4*n +: 2]);
        int lc   = int'(m_ctrl[18+4*n +: 2]);
        bit ovl;
        blen   = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 8 : 4;
        base   = longint'(m_addr[n]) & ~(blen - 1);
        abytes = longint'(1) << acc_size;
        alo    = longint'(acc_addr);
        ovl    = (alo <= base + blen - 1) && (base <= alo + abytes - 1);
        if (kind == 0) return fetch_valid && (fetch_ip == m_addr[n]);
        if (kind == 1) return acc_valid && acc_write && ovl;
        if (kind == 3) return acc_valid && ovl;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(string req);
        logic [3:0] h;
        bit live;
        for (int n = 0; n < 4; n++) h[n] = ref_hit(n);
        live = 1'b0;
        for (int n = 0; n < 4; n++)
            if (h[n] && (m_ctrl[2*n] || m_ctrl[2*n+1])) live = 1'b1;
        if (live || force_upd) m_status = {m_status[31:4], h};
        m_exc = live;
        if (wr_en) begin
            if (wr_sel < 3'd4) m_addr[wr_sel] = wr_data;
            else if (wr_sel == 3'd4) m_ctrl = wr_data;
        end
        @(posedge clk);
        #2;
        check({req, " status"}, status, m_status);
        check({req, " dbg_exc"}, {31'd0, dbg_exc}, {31'd0, m_exc});
        wr_en = 0; fetch_valid = 0; acc_valid = 0; force_upd = 0;
    endtask

    task automatic wr(int sel, logic [31:0] d);
        wr_en = 1; wr_sel = 3'(sel); wr_data = d;
        step("R11 write");
    endtask

    task automatic fetch(logic [31:0] ip);
        fetch_valid = 1; fetch_ip = ip;
    endtask

    task automatic acc(bit w, int sz, logic [31:0] a);
        acc_valid = 1; acc_write = w; acc_size = 2'(sz); acc_addr = a;
    endtask

    initial begin
        #4000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4; n++) m_addr[n] = '0;
        m_ctrl = 32'h0000_0400; m_status = 32'hFFFF_0FF0; m_exc = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        check("R1 reset status", status, 32'hFFFF_0FF0);
        check("R1 reset exc", {31'd0, dbg_exc}, 32'd0);

        // R1/R7/R9: zero addresses, kind 0, all disabled; force with ip 0
        fetch(32'h0); force_upd = 1; step("R1 force zero slots");
        check("R7 all disabled hits recorded", status, 32'hFFFF_0FFF);
        check("R9 force no exc", {31'd0, dbg_exc}, 32'd0);

        wr(0, 32'h0000_1000);
        wr(1, 32'h0000_2003);
        wr(2, 32'h0000_2000);
        wr(3, 32'h0000_3005);
        wr(4, slot_bits(0,1,0,0,0) | slot_bits(1,1,1,1,3) |
              slot_bits(2,1,0,2,0) | slot_bits(3,1,0,3,2));

        fetch(32'h0000_1000); step("R2 exec hit");
        check("R2 status low", status, 32'hFFFF_0FF1);
        check("R9 exc pulse", {31'd0, dbg_exc}, 32'd1);
        step("R9 pulse ends");
        check("R9 exc low", {31'd0, dbg_exc}, 32'd0);
        fetch(32'h0000_1001); step("R2 exec miss");
        acc(0, 2, 32'h0000_2000); step("R3 read ignored");
        check("R3 status held", status, 32'hFFFF_0FF1);
        acc(1, 0, 32'h0000_2001); step("R3 write hit");
        check("R5 io slot silent", status, 32'hFFFF_0FF2);
        acc(1, 1, 32'h0000_1FFF); step("R6 straddle hit");
        acc(1, 2, 32'h0000_2004); step("R6 past end miss");
        acc(0, 0, 32'h0000_3007); step("R4 read hit");
        check("R4 status", status, 32'hFFFF_0FF8);
        acc(1, 0, 32'h0000_3008); step("R6 8-byte end miss");
        acc(1, 3, 32'h0000_2FF8); step("R6 8-byte access miss");
        acc(1, 3, 32'h0000_2FF9); step("R6 8-byte access hit");

        // R10/R8: slot0 disabled; hit does not update
        wr(4, slot_bits(0,0,0,0,0) | slot_bits(3,1,1,3,2));
        fetch(32'h0000_1000); step("R8 disabled no update");
        check("R8 held", status, 32'hFFFF_0FF8);
        fetch(32'h0000_1000); force_upd = 1; step("R7 forced disabled");
        check("R7 forced value", status, 32'hFFFF_0FF1);
        fetch(32'h0000_1000); acc(0, 0, 32'h0000_3000); step("R10 global en");
        check("R7 mixed hits", status, 32'hFFFF_0FF9);

        // R11: write and evaluate in the same cycle
        wr(4, slot_bits(0,1,1,0,0));
        fetch(32'h0000_1000); wr_en = 1; wr_sel = 3'd0; wr_data = 32'h0000_5000;
        step("R11 old value used");
        check("R11 exc", {31'd0, dbg_exc}, 32'd1);
        fetch(32'h0000_1000); step("R11 new value");
        fetch(32'h0000_5000); step("R11 new value hit");

        for (int i = 0; i < 400; i++) begin
            int s = int'($urandom % 4);
            if ($urandom % 4 == 0) begin
                wr_en = 1; wr_sel = 3'($urandom % 5);
                wr_data = (wr_sel == 3'd4) ? $urandom : (32'h0000_4000 + ($urandom % 64));
            end
            if ($urandom % 2 == 0) begin
                fetch_valid = 1;
                fetch_ip = ($urandom % 2 == 0) ? m_addr[s] : (32'h0000_4000 + ($urandom % 64));
            end
            if ($urandom % 2 == 0) begin
                acc_valid = 1; acc_write = 1'($urandom); acc_size = 2'($urandom);
                acc_addr = m_addr[s] + 32'($urandom % 16) - 32'd8;
            end
            force_upd = ($urandom % 8 == 0);
            step("R6 R8 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule